// File: doc/BRIEF.md
# Quad SPI Flash Erase and Page Programmer

This block writes a stream of 32-bit words into a NOR flash over a four-lane SPI bus. The host gives it a page-aligned start address, the number of 4 KB subsectors to clear and the number of 256-byte pages to write. Each value has its own valid strobe. The host then raises the erase request. The engine erases the subsectors one after another and keeps `erasing` high until the last erase has finished inside the flash.

After the erase phase the host pushes data words into a dual-clock FIFO on its own write clock. The engine drains the FIFO on the system clock and writes one page per program command. It moves four data bits per SPI clock. When the counted pages are done it raises `write_done`. The host must supply whole pages and pad the last page itself.

Every erase and every program command is preceded by its own write-enable transaction. The engine learns that an operation is complete by polling the flash status register. It needs no reset to get back to idle, because every job ends there.

Top module: `qspi_flash_writer`

## Requirements
- R1: After reset, chip select is high, SCK is low, `erasing` and `write_done` are low, the FIFO reports empty and almost-empty, and full, almost-full and both error flags are low.
- R2: A job is accepted only in idle, and only in a clock where `erase` and all three valid inputs are high. Holding `erase` while any valid is low, or holding all valids with `erase` low, starts nothing: `erasing` stays low and chip select stays high.
- R3: With a nonzero subsector count, `erasing` is high from the clock after acceptance until the last subsector erase has completed. The flash sees exactly that many subsector-erase transactions, each made of opcode 0x20 and a 24-bit address. The addresses are the start address plus k·0x1000. With a zero count no erase is sent and `erasing` stays low.
- R4: Every erase and every page program comes right after a transaction that holds only opcode 0x06. Chip select goes high for at least one clock between transactions.
- R5: The engine finds completion by repeating a 16-clock transaction: opcode 0x05, then eight clocks in which the flash returns its status byte, most significant bit first, on lane 1. It repeats while status bit 0 is 1 and moves on at the first poll with bit 0 clear.
- R6: Each page is written in one transaction. Opcode 0x32 and a 24-bit address go out on lane 0, most significant bit first. Then 64 words follow, four bits per SCK on lanes 3..0 with lane 3 as the most significant. Within each word the nibbles go most significant first, so a word lands in flash as four bytes in big-endian order. Page addresses are the start address plus p·0x100. All four lanes are driven during data and only lane 0 otherwise.
- R7: `write_done` rises after the last page program has completed, or straight after the erase phase when the page count is zero. It stays high until the next job is accepted.
- R8: On the FIFO write side a word is stored on each `fifo_clk` edge with `fifo_wr_en` high. `fifo_full` is high when 16 words are unread. `fifo_almost_full` is high at 14 or more. A write while full is dropped and sets the sticky `fifo_wr_err`.
- R9: On the read side `fifo_empty` is high with no words, and `fifo_almost_empty` is high with two or fewer. The sticky `fifo_rd_err` flags a read while empty, and the engine never causes one.
- R10: SCK runs at half the system clock. It is high for exactly one system clock per bit, high only while chip select is low, and low when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the sequencer, SPI and FIFO read side |
| rst_n | input | 1 | Active-low asynchronous reset, both domains |
| fifo_clk | input | 1 | FIFO write clock |
| fifo_wr_en | input | 1 | Store `fifo_wdata` on this write clock edge |
| fifo_wdata | input | 32 | Data word to program |
| start_addr | input | 32 | Page-aligned first flash address |
| start_addr_vld | input | 1 | Start address is valid |
| page_count | input | 17 | Number of 256-byte pages to program |
| page_count_vld | input | 1 | Page count is valid |
| subsector_count | input | 13 | Number of 4 KB subsectors to erase |
| subsector_count_vld | input | 1 | Subsector count is valid |
| erase | input | 1 | Request to start a job |
| erasing | output | 1 | Erase phase in progress |
| write_done | output | 1 | All counted pages have been programmed |
| fifo_full | output | 1 | FIFO full (write side) |
| fifo_almost_full | output | 1 | FIFO nearly full (write side) |
| fifo_empty | output | 1 | FIFO empty (read side) |
| fifo_almost_empty | output | 1 | FIFO nearly empty (read side) |
| fifo_wr_err | output | 1 | Sticky: write attempted while full |
| fifo_rd_err | output | 1 | Sticky: read attempted while empty |
| spi_sck | output | 1 | SPI clock |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_dq_o | output | 4 | SPI data lanes out |
| spi_dq_oe | output | 4 | Per-lane output enable |
| spi_miso | input | 1 | Flash data returned on lane 1 |

## Verification
`erasing` and the clearing of `write_done` are due one clock after the accepting edge. The bench drives that edge from a falling edge and samples at the next one. Every SPI bit takes two system clocks, and the flash responder decodes transactions on SCK rising edges, so command, address and data checks do not depend on absolute cycle counts. The end of an erase or program phase depends on how many busy polls the responder returns, so the bench waits on the `erasing` and `write_done` levels under a bound. The empty flag is due two to three read clocks after a write, because of pointer synchronization, while full and almost-full follow on the next write clock. The bench therefore waits several clocks before it samples read-side flags.

// File: rtl/qfw_pkg.sv
package qfw_pkg;
    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_SSE   = 8'h20;
    localparam logic [7:0] OP_QPP   = 8'h32;
    localparam int PAGE_BYTES      = 256;
    localparam int SUBSECTOR_BYTES = 4096;
    localparam int WORD_W          = 32;

    typedef enum logic [3:0] {
        ST_IDLE, ST_WREN_S, ST_WREN_W, ST_CMD_S, ST_CMD_W,
        ST_DAT_S, ST_DAT_W, ST_STAT_S, ST_STAT_W
    } seq_state_e;

    typedef enum logic [1:0] {SH_IDLE, SH_LOW, SH_HIGH} sh_state_e;
endpackage

// File: rtl/qfw_cdc_fifo.sv
module qfw_cdc_fifo #(
    parameter int WIDTH        = 32,
    parameter int AW           = 4,
    parameter int AFULL_MARGIN = 2,
    parameter int AEMPTY_LVL   = 2
) (
    input  logic             wr_clk,
    input  logic             rd_clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [WIDTH-1:0] wr_data_i,
    output logic             full_o,
    output logic             afull_o,
    output logic             wr_err_o,
    input  logic             rd_en_i,
    output logic [WIDTH-1:0] rd_data_o,
    output logic             empty_o,
    output logic             aempty_o,
    output logic             rd_err_o
);
    localparam int DEPTH = 1 << AW;
    localparam int PW    = AW + 1;

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic [PW-1:0] sync1;
        logic [PW-1:0] sync2;
        logic          err;
    } side_t;

    side_t wq, wd, rq, rd;
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0] wcount, rcount;

    function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    // write side
    assign wcount   = wq.bin - g2b(wq.sync2);
    assign full_o   = (wcount == PW'(DEPTH));
    assign afull_o  = (wcount >= PW'(DEPTH - AFULL_MARGIN));
    assign wr_err_o = wq.err;

    always_comb begin
        wd       = wq;
        wd.sync1 = rq.gray;
        wd.sync2 = wq.sync1;
        if (wr_en_i) begin
            if (full_o) begin
                wd.err = 1'b1;
            end else begin
                wd.bin  = wq.bin + 1'b1;
                wd.gray = b2g(wd.bin);
            end
        end
    end

    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) wq <= '0;
        else        wq <= wd;
    end

    always_ff @(posedge wr_clk) begin
        if (wr_en_i && !full_o) mem[wq.bin[AW-1:0]] <= wr_data_i;
    end

    // read side
    assign rcount    = g2b(rq.sync2) - rq.bin;
    assign empty_o   = (rq.gray == rq.sync2);
    assign aempty_o  = (rcount <= PW'(AEMPTY_LVL));
    assign rd_err_o  = rq.err;
    assign rd_data_o = mem[rq.bin[AW-1:0]];

    always_comb begin
        rd       = rq;
        rd.sync1 = wq.gray;
        rd.sync2 = rq.sync1;
        if (rd_en_i) begin
            if (empty_o) begin
                rd.err = 1'b1;
            end else begin
                rd.bin  = rq.bin + 1'b1;
                rd.gray = b2g(rd.bin);
            end
        end
    end

    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) rq <= '0;
        else        rq <= rd;
    end

    assert_no_overflow_R8: assert property (@(posedge wr_clk) disable iff (!rst_n)
        wcount <= PW'(DEPTH));

    assert_read_guard_R9: assert property (@(posedge rd_clk) disable iff (!rst_n)
        rd_en_i |-> !empty_o);
endmodule

// File: rtl/qfw_quad_shifter.sv
module qfw_quad_shifter
    import qfw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              quad_i,
    input  logic [WORD_W-1:0] data_i,
    input  logic [5:0]        nbits_i,
    output logic              done_o,
    output logic              rx_bit_o,
    output logic              sck_o,
    output logic [3:0]        dq_o,
    output logic [3:0]        dq_oe_o,
    input  logic              miso_i
);
    typedef struct packed {
        sh_state_e         st;
        logic [WORD_W-1:0] sr;
        logic [5:0]        cnt;
        logic              quad;
        logic              sck;
        logic [3:0]        dq;
        logic [3:0]        oe;
        logic              rx;
        logic              done;
    } sh_regs_t;

    sh_regs_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            SH_IDLE: begin
                d.sck = 1'b0;
                if (start_i) begin
                    d.st   = SH_LOW;
                    d.sr   = data_i;
                    d.quad = quad_i;
                    d.cnt  = quad_i ? {2'b00, nbits_i[5:2]} : nbits_i;
                    d.oe   = quad_i ? 4'hF : 4'h1;
                    d.dq   = quad_i ? data_i[WORD_W-1 -: 4] : {3'b000, data_i[WORD_W-1]};
                end
            end
            SH_LOW: begin
                d.sck = 1'b1;
                d.st  = SH_HIGH;
            end
            SH_HIGH: begin
                d.sck = 1'b0;
                d.rx  = miso_i;
                d.cnt = q.cnt - 1'b1;
                d.sr  = q.quad ? {q.sr[WORD_W-5:0], 4'h0} : {q.sr[WORD_W-2:0], 1'b0};
                d.dq  = q.quad ? d.sr[WORD_W-1 -: 4] : {3'b000, d.sr[WORD_W-1]};
                if (q.cnt == 6'd1) begin
                    d.st   = SH_IDLE;
                    d.done = 1'b1;
                    d.oe   = 4'h0;
                    d.dq   = 4'h0;
                end else begin
                    d.st = SH_LOW;
                end
            end
            default: d.st = SH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: SH_IDLE, default: '0};
        else        q <= d;
    end

    assign done_o   = q.done;
    assign rx_bit_o = q.rx;
    assign sck_o    = q.sck;
    assign dq_o     = q.dq;
    assign dq_oe_o  = q.oe;

    assert_sck_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.sck) |=> $fell(q.sck));
endmodule

// File: rtl/qfw_sequencer.sv
module qfw_sequencer
    import qfw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int PAGE_W = 17,
    parameter int SEC_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              addr_vld_i,
    input  logic [PAGE_W-1:0] pages_i,
    input  logic              pages_vld_i,
    input  logic [SEC_W-1:0]  secs_i,
    input  logic              secs_vld_i,
    input  logic              fifo_empty_i,
    input  logic [WORD_W-1:0] fifo_data_i,
    output logic              fifo_rd_o,
    output logic              sh_start_o,
    output logic              sh_quad_o,
    output logic [WORD_W-1:0] sh_data_o,
    output logic [5:0]        sh_nbits_o,
    input  logic              sh_done_i,
    input  logic              sh_rx_i,
    output logic              cs_n_o,
    output logic              erasing_o,
    output logic              write_done_o
);
    localparam int WORDS_PER_PAGE = PAGE_BYTES / (WORD_W / 8);
    localparam int WCNT_W         = $clog2(WORDS_PER_PAGE);
    localparam logic [WCNT_W-1:0] LAST_WORD = WCNT_W'(WORDS_PER_PAGE - 1);
    localparam logic [ADDR_W-1:0] SUB_STEP  = ADDR_W'(SUBSECTOR_BYTES);
    localparam logic [ADDR_W-1:0] PAGE_STEP = ADDR_W'(PAGE_BYTES);

    typedef struct packed {
        seq_state_e        st;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] addr;
        logic [PAGE_W-1:0] pages;
        logic [SEC_W-1:0]  secs;
        logic [WCNT_W-1:0] wcnt;
        logic              prog;
        logic              cs_n;
        logic              erasing;
        logic              done;
    } seq_regs_t;

    seq_regs_t q, d;
    logic accept;

    assign accept = erase_i && addr_vld_i && pages_vld_i && secs_vld_i;

    always_comb begin
        d          = q;
        fifo_rd_o  = 1'b0;
        sh_start_o = 1'b0;
        sh_quad_o  = 1'b0;
        sh_data_o  = '0;
        sh_nbits_o = 6'd0;
        unique case (q.st)
            ST_IDLE: begin
                if (accept) begin
                    d.base  = addr_i;
                    d.addr  = addr_i;
                    d.pages = pages_i;
                    d.secs  = secs_i;
                    d.wcnt  = '0;
                    d.done  = 1'b0;
                    if (secs_i != '0) begin
                        d.erasing = 1'b1;
                        d.prog    = 1'b0;
                        d.st      = ST_WREN_S;
                    end else if (pages_i != '0) begin
                        d.prog = 1'b1;
                        d.st   = ST_WREN_S;
                    end else begin
                        d.done = 1'b1;
                    end
                end
            end
            ST_WREN_S: begin
                sh_start_o = 1'b1;
                sh_data_o  = {OP_WREN, 24'h0};
                sh_nbits_o = 6'd8;
                d.cs_n     = 1'b0;
                d.st       = ST_WREN_W;
            end
            ST_WREN_W: begin
                if (sh_done_i) begin
                    d.cs_n = 1'b1;
                    d.st   = ST_CMD_S;
                end
            end
            ST_CMD_S: begin
                sh_start_o = 1'b1;
                sh_data_o  = {(q.prog ? OP_QPP : OP_SSE), q.addr[23:0]};
                sh_nbits_o = 6'd32;
                d.cs_n     = 1'b0;
                d.st       = ST_CMD_W;
            end
            ST_CMD_W: begin
                if (sh_done_i) begin
                    if (q.prog) begin
                        d.st = ST_DAT_S;
                    end else begin
                        d.cs_n = 1'b1;
                        d.st   = ST_STAT_S;
                    end
                end
            end
            ST_DAT_S: begin
                if (!fifo_empty_i) begin
                    fifo_rd_o  = 1'b1;
                    sh_start_o = 1'b1;
                    sh_quad_o  = 1'b1;
                    sh_data_o  = fifo_data_i;
                    sh_nbits_o = 6'd32;
                    d.st       = ST_DAT_W;
                end
            end
            ST_DAT_W: begin
                if (sh_done_i) begin
                    d.wcnt = q.wcnt + 1'b1;
                    if (q.wcnt == LAST_WORD) begin
                        d.cs_n = 1'b1;
                        d.st   = ST_STAT_S;
                    end else begin
                        d.st = ST_DAT_S;
                    end
                end
            end
            ST_STAT_S: begin
                sh_start_o = 1'b1;
                sh_data_o  = {OP_RDSR, 24'h0};
                sh_nbits_o = 6'd16;
                d.cs_n     = 1'b0;
                d.st       = ST_STAT_W;
            end
            ST_STAT_W: begin
                if (sh_done_i) begin
                    d.cs_n = 1'b1;
                    if (sh_rx_i) begin
                        d.st = ST_STAT_S;
                    end else if (!q.prog) begin
                        d.secs = q.secs - 1'b1;
                        d.addr = q.addr + SUB_STEP;
                        d.st   = ST_WREN_S;
                        if (q.secs == SEC_W'(1)) begin
                            d.erasing = 1'b0;
                            d.prog    = 1'b1;
                            d.addr    = q.base;
                            if (q.pages == '0) begin
                                d.done = 1'b1;
                                d.st   = ST_IDLE;
                            end
                        end
                    end else begin
                        d.pages = q.pages - 1'b1;
                        d.addr  = q.addr + PAGE_STEP;
                        d.wcnt  = '0;
                        d.st    = ST_WREN_S;
                        if (q.pages == PAGE_W'(1)) begin
                            d.done = 1'b1;
                            d.st   = ST_IDLE;
                        end
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, cs_n: 1'b1, default: '0};
        else        q <= d;
    end

    assign cs_n_o       = q.cs_n;
    assign erasing_o    = q.erasing;
    assign write_done_o = q.done;

    assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.erasing) |-> $past(erase_i && addr_vld_i && pages_vld_i && secs_vld_i));

    assert_erase_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.erasing) |-> $past(sh_done_i && !sh_rx_i));

    assert_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.done) |-> (q.pages == '0 && !q.erasing));
endmodule

// File: rtl/qspi_flash_writer.sv
module qspi_flash_writer
    import qfw_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int PAGE_W      = 17,
    parameter int SEC_W       = 13,
    parameter int FIFO_AW     = 4,
    parameter int AFULL_MARG  = 2,
    parameter int AEMPTY_LVL  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_clk,
    input  logic              fifo_wr_en,
    input  logic [WORD_W-1:0] fifo_wdata,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              start_addr_vld,
    input  logic [PAGE_W-1:0] page_count,
    input  logic              page_count_vld,
    input  logic [SEC_W-1:0]  subsector_count,
    input  logic              subsector_count_vld,
    input  logic              erase,
    output logic              erasing,
    output logic              write_done,
    output logic              fifo_full,
    output logic              fifo_almost_full,
    output logic              fifo_empty,
    output logic              fifo_almost_empty,
    output logic              fifo_wr_err,
    output logic              fifo_rd_err,
    output logic              spi_sck,
    output logic              spi_cs_n,
    output logic [3:0]        spi_dq_o,
    output logic [3:0]        spi_dq_oe,
    input  logic              spi_miso
);
    logic              rd_en;
    logic [WORD_W-1:0] rd_data;
    logic              sh_start, sh_quad, sh_done, sh_rx;
    logic [WORD_W-1:0] sh_data;
    logic [5:0]        sh_nbits;

    qfw_cdc_fifo #(
        .WIDTH(WORD_W), .AW(FIFO_AW), .AFULL_MARGIN(AFULL_MARG), .AEMPTY_LVL(AEMPTY_LVL)
    ) u_fifo (
        .wr_clk(fifo_clk), .rd_clk(clk), .rst_n(rst_n),
        .wr_en_i(fifo_wr_en), .wr_data_i(fifo_wdata),
        .full_o(fifo_full), .afull_o(fifo_almost_full), .wr_err_o(fifo_wr_err),
        .rd_en_i(rd_en), .rd_data_o(rd_data),
        .empty_o(fifo_empty), .aempty_o(fifo_almost_empty), .rd_err_o(fifo_rd_err)
    );

    qfw_sequencer #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SEC_W(SEC_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .erase_i(erase),
        .addr_i(start_addr), .addr_vld_i(start_addr_vld),
        .pages_i(page_count), .pages_vld_i(page_count_vld),
        .secs_i(subsector_count), .secs_vld_i(subsector_count_vld),
        .fifo_empty_i(fifo_empty), .fifo_data_i(rd_data), .fifo_rd_o(rd_en),
        .sh_start_o(sh_start), .sh_quad_o(sh_quad), .sh_data_o(sh_data),
        .sh_nbits_o(sh_nbits), .sh_done_i(sh_done), .sh_rx_i(sh_rx),
        .cs_n_o(spi_cs_n), .erasing_o(erasing), .write_done_o(write_done)
    );

    qfw_quad_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .start_i(sh_start), .quad_i(sh_quad),
        .data_i(sh_data), .nbits_i(sh_nbits), .done_o(sh_done), .rx_bit_o(sh_rx),
        .sck_o(spi_sck), .dq_o(spi_dq_o), .dq_oe_o(spi_dq_oe), .miso_i(spi_miso)
    );

    assert_sck_in_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sck |-> !spi_cs_n);
endmodule

// File: tb/qspi_flash_writer_bench.sv
module qspi_flash_writer_bench;
    logic clk = 1'b0, fifo_clk = 1'b0, rst_n = 1'b0;
    logic fifo_wr_en = 1'b0;
    logic [31:0] fifo_wdata = '0, start_addr = '0;
    logic start_addr_vld = 1'b0, page_count_vld = 1'b0, subsector_count_vld = 1'b0, erase = 1'b0;
    logic [16:0] page_count = '0;
    logic [12:0] subsector_count = '0;
    logic erasing, write_done, fifo_full, fifo_almost_full, fifo_empty, fifo_almost_empty;
    logic fifo_wr_err, fifo_rd_err, spi_sck, spi_cs_n;
    logic [3:0] spi_dq_o, spi_dq_oe;
    logic spi_miso = 1'b0;

    always #10 clk = ~clk;
    always #15 fifo_clk = ~fifo_clk;

    qspi_flash_writer u_qspi_flash_writer (
        .clk(clk), .rst_n(rst_n), .fifo_clk(fifo_clk), .fifo_wr_en(fifo_wr_en),
        .fifo_wdata(fifo_wdata), .start_addr(start_addr), .start_addr_vld(start_addr_vld),
        .page_count(page_count), .page_count_vld(page_count_vld),
        .subsector_count(subsector_count), .subsector_count_vld(subsector_count_vld),
        .erase(erase), .erasing(erasing), .write_done(write_done),
        .fifo_full(fifo_full), .fifo_almost_full(fifo_almost_full),
        .fifo_empty(fifo_empty), .fifo_almost_empty(fifo_almost_empty),
        .fifo_wr_err(fifo_wr_err), .fifo_rd_err(fifo_rd_err),
        .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_dq_o(spi_dq_o),
        .spi_dq_oe(spi_dq_oe), .spi_miso(spi_miso)
    );

    int checks = 0, fails = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // behavioural flash responder
    int bitn = 0, busy = 0, polls = 0, wrens = 0, wel_err = 0, proto_err = 0, mon_err = 0;
    bit wel = 0;
    logic [7:0]  opc = '0;
    logic [23:0] adr = '0;
    logic [31:0] curword = '0;
    int nib = 0;
    int erase_q[$];
    int prog_q[$];
    logic [7:0] fmem [int];

    always @(posedge spi_sck) begin
        if (bitn < 8) begin
            opc = {opc[6:0], spi_dq_o[0]};
            if (spi_dq_oe != 4'h1) mon_err++;           // R6 lane use
        end else if (opc == 8'h05) begin
            spi_miso <= (bitn == 15) && (busy > 0);      // R5 status bit 0
        end else if (bitn < 32) begin
            adr = {adr[22:0], spi_dq_o[0]};
            if (spi_dq_oe != 4'h1) mon_err++;
        end else if (opc == 8'h32) begin
            if (spi_dq_oe != 4'hF) mon_err++;
            curword = {curword[27:0], spi_dq_o};
            nib++;
            if (nib % 8 == 0)
                for (int k = 0; k < 4; k++)
                    fmem[int'(adr) + (nib / 8 - 1) * 4 + k] = curword[31 - 8 * k -: 8];
        end
        bitn++;
    end

    always @(posedge spi_cs_n) begin
        if (bitn > 0) begin
            if (opc == 8'h06 && bitn == 8) begin
                wel = 1; wrens++;
            end else if (opc == 8'h20 && bitn == 32) begin
                if (!wel) wel_err++;
                if (!erasing) mon_err++;
                wel = 0; erase_q.push_back(int'(adr)); busy = 2;
            end else if (opc == 8'h32 && bitn == 32 + 64 * 8) begin
                if (!wel) wel_err++;
                if (erasing) mon_err++;
                wel = 0; prog_q.push_back(int'(adr)); busy = 3;
            end else if (opc == 8'h05 && bitn == 16) begin
                polls++;
                if (busy > 0) busy--;
            end else begin
                proto_err++;
            end
        end
        bitn = 0; opc = '0; adr = '0; nib = 0;
        spi_miso <= 1'b0;
    end

    // per-clock monitor (R10)
    logic sck_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (spi_sck && spi_cs_n) mon_err++;
            if (spi_sck && sck_prev) mon_err++;
        end
        sck_prev = spi_sck;
    end

    function automatic logic [31:0] pat(input int job, input int g);
        return 32'hA500_0000 ^ (job << 20) ^ (g * 32'h0103_0507);
    endfunction

    task automatic push_word(input logic [31:0] w);
        @(negedge fifo_clk);
        while (fifo_full) @(negedge fifo_clk);
        fifo_wdata = w; fifo_wr_en = 1'b1;
        @(negedge fifo_clk);
        fifo_wr_en = 1'b0;
    endtask

    task automatic run_job(input int job, input logic [31:0] sa, input int pg, input int sc);
        int t, bad;
        erase_q.delete(); prog_q.delete(); fmem.delete();
        polls = 0; wrens = 0; wel_err = 0; proto_err = 0;
        @(negedge clk);
        start_addr = sa; page_count = 17'(pg); subsector_count = 13'(sc);
        start_addr_vld = 1; page_count_vld = 1; subsector_count_vld = 1; erase = 1;
        @(negedge clk);
        erase = 0;
        check(erasing == (sc != 0), "R3", "erasing one clock after accept", erasing, sc != 0);
        check(write_done == 0, "R7", "write_done cleared on accept", write_done, 0);
        t = 0;
        while (erasing && t < 50000) begin @(negedge clk); t++; end
        check(erase_q.size() == sc, "R3", "subsector erase count", erase_q.size(), sc);
        bad = 0;
        foreach (erase_q[i]) if (erase_q[i] != ((int'(sa) + i * 32'h1000) & 32'hFFFFFF)) bad++;
        check(bad == 0, "R3", "erase addresses off", bad, 0);
        for (int g = 0; g < pg * 64; g++) push_word(pat(job, g));
        t = 0;
        while (!write_done && t < 50000) begin @(negedge clk); t++; end
        check(write_done == 1, "R7", "write_done after last page", write_done, 1);
        check(prog_q.size() == pg, "R6", "page program count", prog_q.size(), pg);
        bad = 0;
        foreach (prog_q[i]) if (prog_q[i] != ((int'(sa) + i * 256) & 32'hFFFFFF)) bad++;
        for (int g = 0; g < pg * 64; g++)
            for (int k = 0; k < 4; k++) begin
                logic [31:0] w;
                int a;
                w = pat(job, g);
                a = (int'(sa) & 32'hFFFFFF) + g * 4 + k;
                if (!fmem.exists(a) || fmem[a] != w[31 - 8 * k -: 8]) bad++;
            end
        check(bad == 0, "R6", "page address or big-endian data mismatches", bad, 0);
        check(wrens == sc + pg && wel_err == 0, "R4", "write-enable per operation",
              wrens, sc + pg);
        check(polls == sc * 3 + pg * 4, "R5", "status polls until bit0 clear", polls, sc * 3 + pg * 4);
        check(proto_err == 0, "R4", "malformed transactions", proto_err, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int bad;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(spi_cs_n && !spi_sck && !erasing && !write_done, "R1", "spi/status idle",
              {spi_cs_n, spi_sck, erasing, write_done}, 4'b1000);
        check(fifo_empty && fifo_almost_empty && !fifo_full && !fifo_almost_full
              && !fifo_wr_err && !fifo_rd_err, "R1", "fifo flags",
              {fifo_empty, fifo_almost_empty, fifo_full, fifo_almost_full, fifo_wr_err, fifo_rd_err},
              6'b110000);

        // R2: missing valid or missing erase starts nothing
        bad = 0;
        start_addr = 32'h0001_0000; page_count = 17'd1; subsector_count = 13'd1;
        start_addr_vld = 1; page_count_vld = 0; subsector_count_vld = 1; erase = 1;
        repeat (20) begin @(negedge clk); if (erasing || !spi_cs_n) bad++; end
        check(bad == 0, "R2", "erase with a valid low ignored", bad, 0);
        bad = 0;
        page_count_vld = 1; erase = 0;
        repeat (20) begin @(negedge clk); if (erasing || !spi_cs_n) bad++; end
        check(bad == 0, "R2", "valids without erase ignored", bad, 0);

        run_job(1, 32'h0001_2000, 3, 2);
        repeat (50) @(negedge clk);
        check(write_done == 1, "R7", "write_done held until next job", write_done, 1);
        run_job(2, 32'h0050_0100, 1, 0);
        run_job(3, 32'h0020_0000, 0, 1);
        check(fifo_rd_err == 0, "R9", "engine never reads empty", fifo_rd_err, 0);

        // R8 / R9 FIFO flags with the engine idle
        push_word(32'h1);
        repeat (10) @(negedge clk);
        check(!fifo_empty && fifo_almost_empty, "R9", "one word: not empty, almost empty",
              {fifo_empty, fifo_almost_empty}, 2'b01);
        push_word(32'h2); push_word(32'h3);
        repeat (10) @(negedge clk);
        check(!fifo_almost_empty, "R9", "three words clears almost empty", fifo_almost_empty, 0);
        for (int i = 3; i < 14; i++) push_word(i);
        check(fifo_almost_full && !fifo_full, "R8", "14 words almost full",
              {fifo_almost_full, fifo_full}, 2'b10);
        push_word(32'hE); push_word(32'hF);
        check(fifo_full && !fifo_wr_err, "R8", "16 words full", {fifo_full, fifo_wr_err}, 2'b10);
        @(negedge fifo_clk);
        fifo_wdata = 32'hDEAD; fifo_wr_en = 1'b1;
        @(negedge fifo_clk);
        fifo_wr_en = 1'b0;
        @(negedge fifo_clk);
        check(fifo_wr_err && fifo_full, "R8", "write while full flagged",
              {fifo_wr_err, fifo_full}, 2'b11);

        check(mon_err == 0, "R10", "sck/cs/lane monitor errors", mon_err, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule